// File: doc/BRIEF.md
# Serial PHY Control-Register Access Master

This block turns one host request at a time into a four-phase request/acknowledge exchange on the parallel control-register port of a serial PHY. Several PHY instances may be attached, and an index picks one of them. Each PHY has its own select line, address and write-data lines, read and write enables, acknowledge line and read-data bus. The host gives an address, write data, a direction flag and a one-cycle start pulse. It gets back read data, a one-cycle done pulse and error flags that name the phase that timed out.

Every access has two phases. In the first, the enable is raised and the master waits for acknowledge to go high. In the second, the enable is dropped and the master waits for acknowledge to go low again. Each phase polls acknowledge a bounded number of times, with a fixed number of clock cycles between polls, so the wall-clock spacing follows the clock frequency. Read data is taken at the poll that first sees acknowledge high. Before the first access to a PHY, its select line is raised and the master waits a settle time.

Top module: `phy_reg_master`

## Requirements
- R1: While reset is low and in the cycle after it, host_busy, host_done, host_err, host_err_release, every phy_sel bit, every phy_rd_en and phy_wr_en bit, and all of phy_addr are 0.
- R2: A write drives the address and write data on the chosen PHY's lines at least one cycle before that PHY's phy_wr_en rises. The address stays unchanged while the enable is high. Read and write enables are never both high.
- R3: A read raises phy_rd_en of the chosen PHY. host_rdata takes that PHY's read data at the clock edge where acknowledge is first sampled high, and holds it when host_done pulses.
- R4: In the acknowledge-high phase, acknowledge is polled in the first wait cycle and then every POLL_GAP cycles. If MAX_POLLS polls see it low, the enable drops and host_done and host_err pulse with host_err_release at 0.
- R5: After the enable drops, acknowledge is polled for low with the same spacing and bound. On success host_done pulses alone. If MAX_POLLS polls all see it high, host_done, host_err and host_err_release pulse together.
- R6: The first access to a PHY sets its phy_sel bit and waits SETTLE_CYCLES cycles before the setup cycle. A select bit never falls outside reset, and later accesses to that PHY skip the wait.
- R7: host_busy is high from the cycle after an accepted start until the cycle host_done pulses. A start while busy is ignored.
- R8: host_done is a one-cycle pulse. host_err and host_err_release are high only together with host_done.
- R9: Only the chosen PHY sees a nonzero address or any enable. The lines of every other PHY stay at 0, and phy_addr is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_start | input | 1 | One-cycle request pulse |
| host_write | input | 1 | 1 = write, 0 = read |
| host_phy | input | IDX_W | Index of the target PHY |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Last captured read data |
| host_done | output | 1 | Completion pulse |
| host_err | output | 1 | Timeout, qualified by host_done |
| host_err_release | output | 1 | Timeout was in the acknowledge-low phase |
| host_busy | output | 1 | Access in progress |
| phy_sel | output | NUM_PHY | Per-PHY select, sticky |
| phy_addr | output | NUM_PHY*ADDR_W | Per-PHY address |
| phy_wdata | output | NUM_PHY*DATA_W | Per-PHY write data |
| phy_rd_en | output | NUM_PHY | Per-PHY read enable |
| phy_wr_en | output | NUM_PHY | Per-PHY write enable |
| phy_ack | input | NUM_PHY | Per-PHY acknowledge |
| phy_rdata | input | NUM_PHY*DATA_W | Per-PHY read data |

## Verification
The bench builds the block with two PHYs, POLL_GAP of 4, MAX_POLLS of 10, SETTLE_CYCLES of 3 and 12-bit addresses. With these values a full ten-poll window lasts about forty cycles. That short window lets the bench reach both timeout kinds and acknowledge arriving exactly at the last poll or just after it. A responder in the bench uses programmable delays to set, cycle by cycle, when acknowledge rises and falls.

// File: rtl/phy_reg_pkg.sv
// Shared types for the PHY control-register access master.
// Assumes: consumers import this package before use.
package phy_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SETUP,
        ST_WAIT_HI,
        ST_WAIT_LO
    } xfer_state_t;

endpackage

// File: rtl/phy_reg_poll_timer.sv
// Poll pacing for one handshake phase: flags a poll in the first running
// cycle and then every GAP cycles, and flags the final allowed poll.
// Assumes: clear has priority and is raised one cycle before a phase starts.
module phy_reg_poll_timer #(
    parameter int GAP  = 500,
    parameter int MAXP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic poll,
    output logic last
);

    localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int CNT_W = (MAXP > 1) ? $clog2(MAXP + 1) : 1;

    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: count cycles between polls and the polls already made.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            gap_q <= '0;
            cnt_q <= '0;
        end else if (run) begin
            if (gap_q == '0) begin
                gap_q <= GAP_W'(GAP - 1);
                if (cnt_q != CNT_W'(MAXP - 1))
                    cnt_q <= cnt_q + 1'b1;
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign poll = run && (gap_q == '0);
    assign last = (cnt_q == CNT_W'(MAXP - 1));

endmodule

// File: rtl/phy_reg_lane_mux.sv
// Fans the active access out to one PHY's lines and picks that PHY's
// acknowledge and read data. Unselected PHYs see all zeros.
// Assumes: idx stays stable while active is high.
module phy_reg_lane_mux #(
    parameter int NUM_PHY = 2,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 1
) (
    input  logic                      active,
    input  logic [IDX_W-1:0]          idx,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      rd_en,
    input  logic                      wr_en,
    output logic [NUM_PHY*ADDR_W-1:0] phy_addr,
    output logic [NUM_PHY*DATA_W-1:0] phy_wdata,
    output logic [NUM_PHY-1:0]        phy_rd_en,
    output logic [NUM_PHY-1:0]        phy_wr_en,
    input  logic [NUM_PHY-1:0]        phy_ack,
    input  logic [NUM_PHY*DATA_W-1:0] phy_rdata,
    output logic                      ack_sel,
    output logic [DATA_W-1:0]         rdata_sel
);

    for (genvar p = 0; p < NUM_PHY; p++) begin : g_lane
        logic hit;
        assign hit = active && (idx == IDX_W'(p));
        assign phy_addr[p*ADDR_W +: ADDR_W]  = hit ? addr  : '0;
        assign phy_wdata[p*DATA_W +: DATA_W] = hit ? wdata : '0;
        assign phy_rd_en[p] = hit && rd_en;
        assign phy_wr_en[p] = hit && wr_en;
    end

    // Purpose: return the chosen PHY's acknowledge and read data.
    always_comb begin
        ack_sel   = 1'b0;
        rdata_sel = '0;
        for (int p = 0; p < NUM_PHY; p++) begin
            if (idx == IDX_W'(p)) begin
                ack_sel   = phy_ack[p];
                rdata_sel = phy_rdata[p*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/phy_reg_master.sv
// Top of the PHY control-register access master. Runs one access at a
// time: optional select settle, one setup cycle, the acknowledge-high
// phase, then the acknowledge-low phase, each phase with its own
// bounded poll window.
// Assumes: host_phy < NUM_PHY; SETTLE_CYCLES, POLL_GAP, MAX_POLLS >= 1.
module phy_reg_master
    import phy_reg_pkg::*;
#(
    parameter int NUM_PHY       = 2,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int POLL_GAP      = 500,
    parameter int MAX_POLLS     = 10,
    parameter int SETTLE_CYCLES = 50,
    localparam int IDX_W        = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_start,
    input  logic                      host_write,
    input  logic [IDX_W-1:0]          host_phy,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic [DATA_W-1:0]         host_rdata,
    output logic                      host_done,
    output logic                      host_err,
    output logic                      host_err_release,
    output logic                      host_busy,
    output logic [NUM_PHY-1:0]        phy_sel,
    output logic [NUM_PHY*ADDR_W-1:0] phy_addr,
    output logic [NUM_PHY*DATA_W-1:0] phy_wdata,
    output logic [NUM_PHY-1:0]        phy_rd_en,
    output logic [NUM_PHY-1:0]        phy_wr_en,
    input  logic [NUM_PHY-1:0]        phy_ack,
    input  logic [NUM_PHY*DATA_W-1:0] phy_rdata
);

    localparam int SET_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;

    xfer_state_t       state_q;
    logic              wr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [NUM_PHY-1:0] sel_q;
    logic [SET_W-1:0]  settle_q;
    logic              en_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q, err_q, late_q;

    logic              ack_sel;
    logic [DATA_W-1:0] rdata_sel;
    logic              poll, last, t_clear, t_run;

    assign t_run   = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);
    assign t_clear = (state_q == ST_SETUP) ||
                     ((state_q == ST_WAIT_HI) && poll && ack_sel);

    phy_reg_poll_timer #(
        .GAP  (POLL_GAP),
        .MAXP (MAX_POLLS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (t_clear),
        .run   (t_run),
        .poll  (poll),
        .last  (last)
    );

    phy_reg_lane_mux #(
        .NUM_PHY (NUM_PHY),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_mux (
        .active    (state_q != ST_IDLE),
        .idx       (idx_q),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .rd_en     (en_q && !wr_q),
        .wr_en     (en_q && wr_q),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_rd_en (phy_rd_en),
        .phy_wr_en (phy_wr_en),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .ack_sel   (ack_sel),
        .rdata_sel (rdata_sel)
    );

    // Purpose: sequence one access through settle, setup and both phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wr_q     <= 1'b0;
            idx_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            sel_q    <= '0;
            settle_q <= '0;
            en_q     <= 1'b0;
            rdata_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            late_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            late_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (host_start) begin
                        wr_q    <= host_write;
                        idx_q   <= host_phy;
                        addr_q  <= host_addr;
                        wdata_q <= host_wdata;
                        if (sel_q[host_phy]) begin
                            state_q <= ST_SETUP;
                        end else begin
                            sel_q[host_phy] <= 1'b1;
                            settle_q        <= SET_W'(SETTLE_CYCLES - 1);
                            state_q         <= ST_SETTLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_q == '0)
                        state_q <= ST_SETUP;
                    else
                        settle_q <= settle_q - 1'b1;
                end
                ST_SETUP: begin
                    en_q    <= 1'b1;
                    state_q <= ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (poll) begin
                        if (ack_sel) begin
                            if (!wr_q)
                                rdata_q <= rdata_sel;
                            en_q    <= 1'b0;
                            state_q <= ST_WAIT_LO;
                        end else if (last) begin
                            en_q    <= 1'b0;
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT_LO: begin
                    if (poll) begin
                        if (!ack_sel) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (last) begin
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            late_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign host_busy        = (state_q != ST_IDLE);
    assign host_done        = done_q;
    assign host_err         = err_q;
    assign host_err_release = late_q;
    assign host_rdata       = rdata_q;
    assign phy_sel          = sel_q;

endmodule

// File: rtl/phy_reg_master_chk.sv
// Protocol checker for phy_reg_master, attached by bind.
// Assumes: same NUM_PHY, ADDR_W and SETTLE_CYCLES as the bound instance.
module phy_reg_master_chk #(
    parameter int NUM_PHY       = 2,
    parameter int ADDR_W        = 16,
    parameter int SETTLE_CYCLES = 50
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      host_done,
    input logic                      host_err,
    input logic                      host_err_release,
    input logic                      host_busy,
    input logic [NUM_PHY-1:0]        phy_sel,
    input logic [NUM_PHY-1:0]        phy_rd_en,
    input logic [NUM_PHY-1:0]        phy_wr_en,
    input logic [NUM_PHY*ADDR_W-1:0] phy_addr
);

    p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phy_rd_en | phy_wr_en) <= 1);

    p_no_rd_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rd_en & phy_wr_en) == '0);

    p_addr_before_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(phy_rd_en | phy_wr_en)) |-> $stable(phy_addr));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_done);

    p_release_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_release |-> host_err);

    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_busy) |-> host_done);

    p_sel_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phy_sel) & ~phy_sel) == '0);

    for (genvar p = 0; p < NUM_PHY; p++) begin : g_settle
        logic [31:0] held;
        // Purpose: count cycles the select has been high, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held <= '0;
            else if (phy_sel[p] && held < 32'(SETTLE_CYCLES))
                held <= held + 1;
        end
        p_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (phy_rd_en[p] || phy_wr_en[p]) |-> held >= 32'(SETTLE_CYCLES));
    end

endmodule

bind phy_reg_master phy_reg_master_chk #(
    .NUM_PHY       (NUM_PHY),
    .ADDR_W        (ADDR_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_done        (host_done),
    .host_err         (host_err),
    .host_err_release (host_err_release),
    .host_busy        (host_busy),
    .phy_sel          (phy_sel),
    .phy_rd_en        (phy_rd_en),
    .phy_wr_en        (phy_wr_en),
    .phy_addr         (phy_addr)
);

// File: tb/sim_phy_reg_master.sv
// Bench: PHY responder with programmable delays, a behavioural reference
// model, and a per-cycle comparison plus directed end-of-access checks.
module sim_phy_reg_master;

    localparam int NP = 2, AW = 12, DW = 16, GAP = 4, MAXP = 10, SETTLE = 3;
    localparam int IW = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_start = 1'b0, host_write = 1'b0;
    logic [IW-1:0] host_phy = '0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic host_done, host_err, host_err_release, host_busy;
    logic [NP-1:0] phy_sel, phy_rd_en, phy_wr_en;
    logic [NP*AW-1:0] phy_addr;
    logic [NP*DW-1:0] phy_wdata, phy_rdata;
    logic [NP-1:0] phy_ack;

    int n_chk = 0, n_err = 0, cyc = 0;
    int hi_dly = 2, lo_dly = 1;
    bit running = 0;

    always #10 clk = ~clk;

    phy_reg_master #(
        .NUM_PHY(NP), .ADDR_W(AW), .DATA_W(DW),
        .POLL_GAP(GAP), .MAX_POLLS(MAXP), .SETTLE_CYCLES(SETTLE)
    ) u0 (.*);

    function automatic logic [DW-1:0] rdpat(int p, logic [AW-1:0] a);
        return {4'(p), a} ^ 16'hC3C3;
    endfunction

    for (genvar p = 0; p < NP; p++) begin : g_rd
        assign phy_rdata[p*DW +: DW] = rdpat(p, phy_addr[p*AW +: AW]);
    end

    // PHY responder: ack rises hi_dly cycles into the enable, falls lo_dly after.
    int hi_cnt [NP];
    int lo_cnt [NP];
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                phy_ack[p] <= 1'b0; hi_cnt[p] <= 0; lo_cnt[p] <= 0;
            end else if (phy_rd_en[p] || phy_wr_en[p]) begin
                lo_cnt[p] <= 0;
                if (!phy_ack[p]) begin
                    if (hi_cnt[p] >= hi_dly) phy_ack[p] <= 1'b1;
                    else hi_cnt[p] <= hi_cnt[p] + 1;
                end
            end else begin
                hi_cnt[p] <= 0;
                if (phy_ack[p]) begin
                    if (lo_cnt[p] >= lo_dly) phy_ack[p] <= 1'b0;
                    else lo_cnt[p] <= lo_cnt[p] + 1;
                end
            end
        end
    end

    // Reference model: phase number plus cycles-in-phase counter.
    int m_ph = 0, m_k = 0, m_phy = 0;
    bit m_busy, m_done, m_err, m_late, m_wr, m_en;
    bit [NP-1:0] m_sel;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_rd;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_k = 0; m_busy = 0; m_done = 0; m_err = 0; m_late = 0;
            m_en = 0; m_sel = '0; m_rd = '0; m_wr = 0; m_addr = '0; m_phy = 0;
        end else begin
            m_done = 0; m_err = 0; m_late = 0;
            case (m_ph)
                0: if (host_start) begin
                    m_wr = host_write; m_phy = int'(host_phy); m_addr = host_addr;
                    m_busy = 1;
                    if (m_sel[m_phy]) m_ph = 2;
                    else begin m_sel[m_phy] = 1; m_ph = 1; m_k = 0; end
                end
                1: begin m_k++; if (m_k == SETTLE) m_ph = 2; end
                2: begin m_en = 1; m_ph = 3; m_k = 0; end
                3: if (m_k % GAP == 0 && phy_ack[m_phy]) begin
                        if (!m_wr) m_rd = rdpat(m_phy, m_addr);
                        m_en = 0; m_ph = 4; m_k = 0;
                    end else if (m_k % GAP == 0 && m_k / GAP == MAXP - 1) begin
                        m_en = 0; m_ph = 0; m_busy = 0; m_done = 1; m_err = 1;
                    end else m_k++;
                4: if (m_k % GAP == 0 && !phy_ack[m_phy]) begin
                        m_ph = 0; m_busy = 0; m_done = 1;
                    end else if (m_k % GAP == 0 && m_k / GAP == MAXP - 1) begin
                        m_ph = 0; m_busy = 0; m_done = 1; m_err = 1; m_late = 1;
                    end else m_k++;
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && running) begin
            logic [NP-1:0] ew, er;
            logic [NP*AW-1:0] ea;
            ew = (m_en && m_wr)  ? NP'(1) << m_phy : '0;
            er = (m_en && !m_wr) ? NP'(1) << m_phy : '0;
            ea = m_busy ? (NP*AW)'(m_addr) << (m_phy * AW) : '0;
            chk("R7 busy", 32'(host_busy), 32'(m_busy));
            chk("R8 done", 32'(host_done), 32'(m_done));
            chk("R4 err", 32'(host_err), 32'(m_err));
            chk("R5 err_release", 32'(host_err_release), 32'(m_late));
            chk("R6 sel", 32'(phy_sel), 32'(m_sel));
            chk("R2 wr_en", 32'(phy_wr_en), 32'(ew));
            chk("R3 rd_en", 32'(phy_rd_en), 32'(er));
            chk("R9 addr", 32'(phy_addr), 32'(ea));
            if (m_done && !m_wr && !m_err)
                chk("R3 rdata", 32'(host_rdata), 32'(m_rd));
        end
    end

    logic [DW-1:0] r_rdata;
    bit r_err, r_late;

    task automatic access(bit wr, int p, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        host_start = 1; host_write = wr; host_phy = IW'(p);
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_start = 0;
        for (int i = 0; i < 2000 && !host_done; i++) @(negedge clk);
        r_rdata = host_rdata; r_err = host_err; r_late = host_err_release;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 32'(host_busy), 0);
        chk("R1 reset sel", 32'(phy_sel), 0);
        chk("R1 reset en", 32'(phy_rd_en | phy_wr_en), 0);
        chk("R1 reset done", 32'(host_done | host_err | host_err_release), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset addr", 32'(phy_addr), 0);
        running = 1;

        access(1, 0, 12'h123, 16'hBEEF);          // R2 R6 first access settles
        chk("R2 write ok", 32'(r_err), 0);
        access(0, 0, 12'h045, 16'h0);             // R3 read, no settle
        chk("R3 read data", 32'(r_rdata), 32'(rdpat(0, 12'h045)));
        access(0, 1, 12'h7FF, 16'h0);             // R6 R9 second PHY
        chk("R9 phy1 data", 32'(r_rdata), 32'(rdpat(1, 12'h7FF)));

        hi_dly = 1000;                            // R4 ack never rises
        access(1, 1, 12'h010, 16'h5555);
        chk("R4 high timeout", 32'({r_err, r_late}), 32'h2);
        hi_dly = 35;                              // R4 ack at the last poll
        access(0, 0, 12'h0F0, 16'h0);
        chk("R4 last poll ok", 32'(r_err), 0);
        chk("R4 last poll data", 32'(r_rdata), 32'(rdpat(0, 12'h0F0)));
        hi_dly = 36;                              // R4 just past the window
        access(0, 0, 12'h0F1, 16'h0);
        chk("R4 just late", 32'({r_err, r_late}), 32'h2);

        hi_dly = 2; lo_dly = 1000;                // R5 ack never falls
        access(1, 0, 12'h222, 16'h1234);
        chk("R5 release timeout", 32'({r_err, r_late}), 32'h3);
        lo_dly = 0;
        repeat (4) @(negedge clk);
        lo_dly = 35;                              // R5 release at last poll
        access(1, 1, 12'h333, 16'h4321);
        chk("R5 release last poll", 32'({r_err, r_late}), 32'h0);
        lo_dly = 1;

        hi_dly = 20;                              // R7 start while busy
        @(negedge clk);
        host_start = 1; host_write = 0; host_phy = 1; host_addr = 12'h0AA;
        @(negedge clk);
        host_start = 0;
        repeat (5) @(negedge clk);
        host_start = 1; host_write = 1; host_phy = 0; host_addr = 12'h555;
        @(negedge clk);
        host_start = 0;
        for (int i = 0; i < 2000 && !host_done; i++) @(negedge clk);
        chk("R7 first access kept", 32'(host_rdata), 32'(rdpat(1, 12'h0AA)));
        repeat (4) @(negedge clk);
        chk("R7 ignored start left idle", 32'(host_busy), 0);

        running = 0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule